// File: doc/BRIEF.md
# Deadlock Escape Recovery Controller

This block sits beside a router's network interface and pulls the router out of a routing deadlock without dropping a packet. Every router input channel has a stall timer. When a channel has held a flit without moving for a set number of cycles, the controller grants that one channel an escape. The router then forces the flits of that channel's packet out of the local ejection port, each marked with an escape tag.

On the ejection side, tagged flits are steered into an internal recovery buffer and untagged flits go on to the normal ejection output. When the tail of the escaped packet has been captured, the buffered packet is written back into the local injection queue. It enters the queue ahead of the core's traffic but never in the middle of a core packet. The flits then leave as an ordinary packet and the circular wait is broken.

Top module: `esc_recovery`

## Requirements
- R1: A channel's stall count increases by one on every clock in which its `chValid` bit is high and its `chProgress` bit is low. The count saturates at `TIMEOUT`, and the channel then counts as blocked. An escape grant for a channel that has stalled from a cleared count appears on `escGrant` exactly `TIMEOUT+1` clocks after the stall begins.
- R2: A clock with `chProgress` high, or with `chValid` low, clears that channel's count, so the timeout restarts from zero.
- R3: An ejected flit with `ejTag`=1 never appears on `ejOutValid`. An ejected flit with `ejTag`=0 appears on `ejOutValid`/`ejOutFlit` in the same cycle.
- R4: At most one escape is active. Among blocked channels, the lowest index wins. `escGrant` is one-hot (bit n = channel n) and holds until a tagged flit with `ejLast`=1 is accepted, after which it reads zero on the next cycle.
- R5: The buffer releases nothing until the tail arrives. It then pushes the flits in arrival order, one per cycle, starting the cycle after the tail. `qLast` is high on the final flit.
- R6: While a complete escape packet waits and the core is at a packet boundary, `coreReady` is low, so escape flits take precedence.
- R7: An escape flit is pushed only when `qFull` is low. A drain starts only when `qBusy` is low. A `qFull` cycle in mid-drain pauses the drain, and the core stays held.
- R8: The buffer holds up to `PKT_MAX` flits. No new grant is issued while it is occupied. A pending blocked channel is granted two cycles after the last buffered flit is pushed.
- R9: Once a core packet has pushed its first flit, its remaining flits are never interleaved with escape flits.
- R10: After reset, `escGrant` is zero, nothing is pushed, and `coreReady` follows `!qFull`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| chValid | input | NUM_CH | Channel n holds a flit |
| chProgress | input | NUM_CH | Channel n moved a flit this cycle |
| escGrant | output | NUM_CH | One-hot: channel granted an escape |
| ejValid | input | 1 | Ejection flit valid |
| ejTag | input | 1 | Ejection flit carries the escape tag |
| ejLast | input | 1 | Ejection flit is a packet tail |
| ejFlit | input | FLIT_W | Ejection flit data |
| ejOutValid | output | 1 | Normal ejection flit valid |
| ejOutFlit | output | FLIT_W | Normal ejection flit data |
| coreValid | input | 1 | Core offers an injection flit |
| coreLast | input | 1 | Core flit is a packet tail |
| coreFlit | input | FLIT_W | Core flit data |
| coreReady | output | 1 | Core flit accepted this cycle |
| qFull | input | 1 | Injection queue full |
| qBusy | input | 1 | Injection queue cannot start an escape packet |
| qPush | output | 1 | Write strobe into injection queue |
| qFlit | output | FLIT_W | Flit written into injection queue |
| qLast | output | 1 | Written flit is a packet tail |

## Verification
The cycle-level properties are checked on every clock: an escape flit never enters a full queue, a grant stays stable until its tagged tail is seen, no grant starts while the buffer is occupied, the buffer never overflows, a new grant names a channel that was holding a flit, and no escape flit follows a core non-tail flit. The following can only be shown by the bench's scenarios: the exact timeout cycle, the effect of a progress pulse in mid-count, the order and contiguity of drained flits, the two-cycle handover to a pending channel, and the core resuming after a drain. These scenarios are swept across every channel and every packet length from one to `PKT_MAX`.

// File: rtl/esc_pkg.sv
package esc_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic wr;     // capture ejection flit into buffer
    logic rd;     // drive buffered flit into injection queue
    logic flush;  // this read is the final buffered flit
  } escStrobe_t;
endpackage

// File: rtl/esc_timeout.sv
module esc_timeout #(
  parameter int NUM_CH  = 4,
  parameter int TIMEOUT = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chValid,
  input  logic [NUM_CH-1:0] chProgress,
  output logic [NUM_CH-1:0] blocked
);
  localparam int CNT_W = $clog2(TIMEOUT + 1);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [CNT_W-1:0] stallCnt;
    always_ff @(posedge clk) begin
      if (!rstN || !chValid[c] || chProgress[c]) stallCnt <= '0;
      else if (stallCnt != CNT_W'(TIMEOUT))      stallCnt <= stallCnt + 1'b1;
    end
    assign blocked[c] = (stallCnt == CNT_W'(TIMEOUT));
  end
endmodule

// File: rtl/esc_ctrl.sv
module esc_ctrl
  import esc_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int PKT_MAX = 5,
  localparam int IDX_W  = $clog2(NUM_CH),
  localparam int OCC_W  = $clog2(PKT_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] blocked,
  input  logic              ejValid,
  input  logic              ejTag,
  input  logic              ejLast,
  input  logic              coreValid,
  input  logic              coreLast,
  input  logic              qFull,
  input  logic              qBusy,
  output logic [NUM_CH-1:0] escGrant,
  output logic              coreReady,
  output escStrobe_t        strobe,
  output logic [OCC_W-1:0]  latchOcc
);
  logic             escActive;
  logic [IDX_W-1:0] escCh;
  logic [IDX_W-1:0] pickCh;
  logic             tailIn;
  logic             draining;
  logic [OCC_W-1:0] rdCnt;
  logic             coreMid;
  logic             corePush;
  logic             startEsc;

  // lowest-index blocked channel wins
  always_comb begin
    pickCh = '0;
    for (int i = NUM_CH - 1; i >= 0; i--)
      if (blocked[i]) pickCh = IDX_W'(i);
  end

  assign startEsc = !escActive && (latchOcc == '0) && (|blocked);

  always_comb begin
    escGrant = '0;
    if (escActive) escGrant[escCh] = 1'b1;
  end

  always_comb begin
    strobe.wr    = ejValid && ejTag && !tailIn;
    strobe.rd    = tailIn && !qFull && (draining || (!qBusy && !coreMid));
    strobe.flush = strobe.rd && (rdCnt == latchOcc - OCC_W'(1));
  end

  assign coreReady = !qFull && !draining && !(tailIn && !coreMid);
  assign corePush  = coreValid && coreReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      escActive <= 1'b0;
      escCh     <= '0;
      latchOcc  <= '0;
      tailIn    <= 1'b0;
      draining  <= 1'b0;
      rdCnt     <= '0;
      coreMid   <= 1'b0;
    end else begin
      if (startEsc) begin
        escActive <= 1'b1;
        escCh     <= pickCh;
      end else if (escActive && strobe.wr && ejLast) begin
        escActive <= 1'b0;
      end

      if (strobe.flush) begin
        latchOcc <= '0;
        tailIn   <= 1'b0;
        draining <= 1'b0;
        rdCnt    <= '0;
      end else begin
        if (strobe.wr) begin
          latchOcc <= latchOcc + 1'b1;
          if (ejLast) tailIn <= 1'b1;
        end
        if (strobe.rd) begin
          draining <= 1'b1;
          rdCnt    <= rdCnt + 1'b1;
        end
      end

      if (corePush) coreMid <= !coreLast;
    end
  end
endmodule

// File: rtl/esc_datapath.sv
module esc_datapath
  import esc_pkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int PKT_MAX = 5,
  localparam int PTR_W  = $clog2(PKT_MAX)
) (
  input  logic              clk,
  input  logic              rstN,
  input  escStrobe_t        strobe,
  input  logic              ejValid,
  input  logic              ejTag,
  input  logic [FLIT_W-1:0] ejFlit,
  input  logic              coreValid,
  input  logic              coreReady,
  input  logic              coreLast,
  input  logic [FLIT_W-1:0] coreFlit,
  output logic              ejOutValid,
  output logic [FLIT_W-1:0] ejOutFlit,
  output logic              qPush,
  output logic [FLIT_W-1:0] qFlit,
  output logic              qLast
);
  logic [FLIT_W-1:0] store [PKT_MAX];
  logic [PTR_W-1:0]  wrPtr;
  logic [PTR_W-1:0]  rdPtr;

  always_ff @(posedge clk) begin
    if (strobe.wr) store[wrPtr] <= ejFlit;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strobe.wr) wrPtr <= wrPtr + 1'b1;
      if (strobe.rd) rdPtr <= rdPtr + 1'b1;
    end
  end

  // tag-steered ejection
  assign ejOutValid = ejValid && !ejTag;
  assign ejOutFlit  = ejFlit;

  // injection multiplexer: buffered flits win
  assign qPush = strobe.rd || (coreValid && coreReady);
  assign qFlit = strobe.rd ? store[rdPtr] : coreFlit;
  assign qLast = strobe.rd ? strobe.flush : coreLast;
endmodule

// File: rtl/esc_recovery.sv
module esc_recovery
  import esc_pkg::*;
#(
  parameter int NUM_CH  = 4,
  parameter int FLIT_W  = 16,
  parameter int TIMEOUT = 32,
  parameter int PKT_MAX = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] chValid,
  input  logic [NUM_CH-1:0] chProgress,
  output logic [NUM_CH-1:0] escGrant,
  input  logic              ejValid,
  input  logic              ejTag,
  input  logic              ejLast,
  input  logic [FLIT_W-1:0] ejFlit,
  output logic              ejOutValid,
  output logic [FLIT_W-1:0] ejOutFlit,
  input  logic              coreValid,
  input  logic              coreLast,
  input  logic [FLIT_W-1:0] coreFlit,
  output logic              coreReady,
  input  logic              qFull,
  input  logic              qBusy,
  output logic              qPush,
  output logic [FLIT_W-1:0] qFlit,
  output logic              qLast
);
  localparam int OCC_W = $clog2(PKT_MAX + 1);

  logic [NUM_CH-1:0] blocked;
  escStrobe_t        strobe;
  logic [OCC_W-1:0]  latchOcc;

  esc_timeout #(.NUM_CH(NUM_CH), .TIMEOUT(TIMEOUT)) i_timeout (
    .clk, .rstN, .chValid, .chProgress, .blocked
  );

  esc_ctrl #(.NUM_CH(NUM_CH), .PKT_MAX(PKT_MAX)) i_ctrl (
    .clk, .rstN, .blocked, .ejValid, .ejTag, .ejLast, .coreValid, .coreLast,
    .qFull, .qBusy, .escGrant, .coreReady, .strobe, .latchOcc
  );

  esc_datapath #(.FLIT_W(FLIT_W), .PKT_MAX(PKT_MAX)) i_dp (
    .clk, .rstN, .strobe, .ejValid, .ejTag, .ejFlit, .coreValid, .coreReady,
    .coreLast, .coreFlit, .ejOutValid, .ejOutFlit, .qPush, .qFlit, .qLast
  );
endmodule

// File: rtl/esc_recovery_chk.sv
module esc_recovery_chk #(
  parameter int NUM_CH  = 4,
  parameter int PKT_MAX = 5,
  localparam int OCC_W  = $clog2(PKT_MAX + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic [NUM_CH-1:0] chValid,
  input logic [NUM_CH-1:0] escGrant,
  input logic              ejValid,
  input logic              ejTag,
  input logic              ejLast,
  input logic              coreValid,
  input logic              coreLast,
  input logic              coreReady,
  input logic              qFull,
  input logic              qPush,
  input logic [OCC_W-1:0]  latchOcc
);
  logic escPush;
  logic corePush;
  assign corePush = coreValid && coreReady;
  assign escPush  = qPush && !corePush;

  // R1
  grant_from_stalled_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|escGrant) |-> (($past(chValid) & escGrant) != '0));

  // R4
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((escGrant != '0) && !(ejValid && ejTag && ejLast)) |=> (escGrant == $past(escGrant)));

  // R4
  grant_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((escGrant != '0) && ejValid && ejTag && ejLast) |=> (escGrant == '0));

  // R7
  push_not_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    escPush |-> !qFull);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchOcc == OCC_W'(PKT_MAX)) |-> !(ejValid && ejTag));

  // R8
  no_grant_occupied_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((latchOcc != '0) && (escGrant == '0)) |=> (escGrant == '0));

  // R9
  no_interleave_chk: assert property (@(posedge clk) disable iff (!rstN)
    (corePush && !coreLast) |=> !escPush);
endmodule

bind esc_recovery esc_recovery_chk #(.NUM_CH(NUM_CH), .PKT_MAX(PKT_MAX)) i_chk (
  .clk(clk), .rstN(rstN), .chValid(chValid), .escGrant(escGrant),
  .ejValid(ejValid), .ejTag(ejTag), .ejLast(ejLast), .coreValid(coreValid),
  .coreLast(coreLast), .coreReady(coreReady), .qFull(qFull), .qPush(qPush),
  .latchOcc(latchOcc)
);

// File: tb/test_esc_recovery.sv
`timescale 1ns/1ps
module test_esc_recovery;
  localparam int NUM_CH  = 4;
  localparam int FLIT_W  = 16;
  localparam int TIMEOUT = 32;
  localparam int PKT_MAX = 5;

  logic clk = 1'b0;
  logic rstN;
  logic [NUM_CH-1:0] chValid, chProgress, escGrant;
  logic ejValid, ejTag, ejLast, ejOutValid;
  logic [FLIT_W-1:0] ejFlit, ejOutFlit, coreFlit, qFlit;
  logic coreValid, coreLast, coreReady, qFull, qBusy, qPush, qLast;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  esc_recovery #(.NUM_CH(NUM_CH), .FLIT_W(FLIT_W), .TIMEOUT(TIMEOUT), .PKT_MAX(PKT_MAX))
    i_esc_recovery (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [FLIT_W-1:0] pat(input int ch, input int len, input int i);
    return FLIT_W'((ch << 8) | (len << 4) | i);
  endfunction

  // stall channel ch from a cleared count and expect grant at TIMEOUT+1
  task automatic waitGrant(input int ch, input bit pulse);
    @(negedge clk);
    chValid = NUM_CH'(1 << ch);
    chProgress = '0;
    if (pulse) begin
      repeat (20) @(negedge clk);
      chProgress = NUM_CH'(1 << ch);
      @(negedge clk);
      chProgress = '0;
    end
    repeat (TIMEOUT) @(negedge clk);
    #1 chk(pulse ? "R2" : "R1", 32'(escGrant), 32'h0);
    @(negedge clk);
    #1 chk("R1", 32'(escGrant), 32'(1 << ch));
  endtask

  // mode bits: 2 qFull before drain, 4 qBusy before drain, 8 pause mid-drain
  task automatic fillDrain(input int ch, input int len, input int mode);
    @(negedge clk);
    ejValid = 1'b1; ejTag = 1'b0; ejLast = 1'b0; ejFlit = FLIT_W'(16'hA000 | ch);
    #1 chk("R3", 32'(ejOutValid), 32'h1);
    chk("R3", 32'(ejOutFlit), 32'(16'hA000 | ch));
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      ejTag = 1'b1; ejFlit = pat(ch, len, i); ejLast = (i == len - 1); qFull = 1'b1;
      #1 chk("R3", 32'(ejOutValid), 32'h0);
      chk("R5", 32'(qPush), 32'h0);
    end
    @(negedge clk);
    ejValid = 1'b0; ejLast = 1'b0;
    coreValid = 1'b1; coreFlit = 16'hC000; coreLast = 1'b1;
    qFull = mode[1]; qBusy = mode[2];
    #1 chk("R4", 32'(escGrant), 32'h0);
    chk("R6", 32'(coreReady), 32'h0);
    if (mode[1] || mode[2]) begin
      chk("R7", 32'(qPush), 32'h0);
      @(negedge clk);
      #1 chk("R7", 32'(qPush), 32'h0);
      chk("R6", 32'(coreReady), 32'h0);
      @(negedge clk);
      qFull = 1'b0; qBusy = 1'b0;
      #1;
    end
    for (int i = 0; i < len; i++) begin
      if (mode[3] && i == 1) begin
        qFull = 1'b1;
        #1 chk("R7", 32'(qPush), 32'h0);
        chk("R7", 32'(coreReady), 32'h0);
        @(negedge clk);
        qFull = 1'b0;
        #1;
      end
      chk("R5", 32'(qPush), 32'h1);
      chk("R5", 32'(qFlit), 32'(pat(ch, len, i)));
      chk("R5", 32'(qLast), 32'(i == len - 1));
      chk("R6", 32'(coreReady), 32'h0);
      chk("R8", 32'(escGrant), 32'h0);
      @(negedge clk);
      #1;
    end
    chk("R6", 32'(coreReady), 32'h1);
    chk("R6", 32'(qFlit), 32'hC000);
    @(negedge clk);
    coreValid = 1'b0; coreLast = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; chValid = '0; chProgress = '0;
    ejValid = 0; ejTag = 0; ejLast = 0; ejFlit = '0;
    coreValid = 0; coreLast = 0; coreFlit = '0; qFull = 0; qBusy = 0;
    repeat (3) @(negedge clk);
    #1 chk("R10", 32'(escGrant), 32'h0);
    chk("R10", 32'(qPush), 32'h0);
    chk("R10", 32'(coreReady), 32'h1);
    rstN = 1'b1;

    // sweep every channel and every packet length
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int len = 1; len <= PKT_MAX; len++) begin
        int mode;
        mode = 0;
        if (ch == 1) mode |= 2;
        if (ch == 2) mode |= 4;
        if (len >= 3 && (ch % 2 == 1)) mode |= 8;
        waitGrant(ch, len == 3);
        chValid = '0;
        fillDrain(ch, len, mode);
        #1 chk("R8", 32'(escGrant), 32'h0);
      end
    end

    // lowest index wins; pending channel waits for empty buffer
    @(negedge clk);
    chValid = 4'b0110;
    repeat (TIMEOUT + 1) @(negedge clk);
    #1 chk("R4", 32'(escGrant), 32'b0010);
    chValid = 4'b0100;
    fillDrain(1, 2, 0);
    #1 chk("R8", 32'(escGrant), 32'b0100);
    chValid = '0;
    fillDrain(2, 1, 0);

    // core packet in flight is not interleaved
    waitGrant(3, 1'b0);
    chValid = '0;
    @(negedge clk);
    ejValid = 1; ejTag = 1; ejLast = 0; ejFlit = 16'hE000;
    coreValid = 1; coreFlit = 16'hC001; coreLast = 0; qFull = 0;
    #1 chk("R9", 32'(qFlit), 32'hC001);
    chk("R9", 32'(coreReady), 32'h1);
    @(negedge clk);
    ejFlit = 16'hE001; ejLast = 1; coreFlit = 16'hC002;
    #1 chk("R9", 32'(qFlit), 32'hC002);
    @(negedge clk);
    ejValid = 0; ejLast = 0; coreFlit = 16'hC003; coreLast = 1;
    #1 chk("R9", 32'(coreReady), 32'h1);
    chk("R9", 32'(qFlit), 32'hC003);
    @(negedge clk);
    coreFlit = 16'hC004; coreLast = 1;
    #1 chk("R6", 32'(coreReady), 32'h0);
    chk("R5", 32'(qFlit), 32'hE000);
    @(negedge clk);
    #1 chk("R5", 32'(qFlit), 32'hE001);
    chk("R5", 32'(qLast), 32'h1);
    @(negedge clk);
    #1 chk("R9", 32'(coreReady), 32'h1);
    chk("R9", 32'(qFlit), 32'hC004);
    @(negedge clk);
    coreValid = 0; coreLast = 0;
    repeat (2) @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #4000000;
    if (!done) begin
      nFails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule